// File: doc/BRIEF.md
# Multi-Mode Serial Identification Responder

This block is the target-side logic of a serial flash that answers identification requests. It watches an active-low chip select and a set of up to four data lines, takes in an 8-bit command and, if it recognises the code, shifts out an identification reply. The reply is a manufacturer byte followed by two device bytes. In single-line (extended) mode, a block of unique-ID bytes follows them. The host chooses how many data lines carry each transfer: one, two or four. The command and the reply both use that line count, except in single-line mode. There the command enters on line 0 and the reply leaves on line 1.

All logic runs on the serial clock. The host drives its data bits ahead of each rising edge. The block registers each new reply chunk on a rising edge, so the host samples it on the following rising edge. Tri-state control is exposed as a per-line output enable. The reply contents and both command codes are parameters. The line count comes from a static mode input, which is held constant while chip select is low.

Top module: `spi_id_responder`

## Requirements
- R1: While `rst` is high, `dq_oe` is 0 on every clock that follows the first reset edge, whatever `cs_n` and `dq_in` do.
- R2: The command is taken most significant bit first, one chunk per rising edge, starting at the first rising edge with `cs_n` low. Single-line mode uses `dq_in[0]` over 8 edges. Dual mode uses `dq_in[1:0]` over 4 edges, with `dq_in[1]` as the higher bit. Quad mode uses `dq_in[3:0]` over 2 edges, with `dq_in[3]` highest. `dq_oe` stays 0 until the edge that takes the last command chunk.
- R3: In single-line mode (`mode`=0), if the command is `CMD_ID` (default 8'h9E), the reply is `MFR_ID`, then `DEV_ID` high byte, then `DEV_ID` low byte, then the `UID_BYTES` bytes of `UID_VALUE` starting with its most significant byte. It is sent one bit per edge, MSB first, on `dq_out[1]` alone, with `dq_oe`=4'b0010.
- R4: In dual mode (`mode`=1), if the command is `CMD_MIO_ID` (default 8'hAF), the reply is the manufacturer byte and then the two device bytes, two bits per edge on `dq_out[1:0]` (`dq_out[1]` higher), with `dq_oe`=4'b0011. No unique-ID bytes follow.
- R5: In quad mode (`mode`=2), if the command is `CMD_MIO_ID`, the same three bytes leave four bits per edge on `dq_out[3:0]` (`dq_out[3]` highest), with `dq_oe`=4'b1111.
- R6: The first reply chunk appears on the edge that takes the last command chunk. Each later edge presents the next chunk. The edge after the last chunk sets `dq_oe` to 0, and it stays 0 until `cs_n` goes high.
- R7: Any other command code leaves `dq_oe` at 0 until `cs_n` goes high. This includes `CMD_ID` sent in dual or quad mode and `CMD_MIO_ID` sent in single-line mode.
- R8: The first rising edge with `cs_n` high sets `dq_oe` to 0 and clears the bit count. The next transfer is decoded from its first edge, whatever point the earlier one had reached.
- R9: `mode`=3 behaves exactly as single-line mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low; high aborts and idles the block |
| mode | input | 2 | Line count: 0 single, 1 dual, 2 quad, 3 single |
| dq_in | input | 4 | Data lines as seen by the target |
| dq_out | output | 4 | Registered reply data |
| dq_oe | output | 4 | Registered per-line drive enable; 0 means high impedance |

## Verification
Let C be the number of command edges (8, 4 or 2) and T the number of reply chunks. The rising edge with index C-1 (counting from 0 after `cs_n` falls) takes the last command chunk and also loads reply chunk 0. Chunk p is therefore visible after edge C-1+p, and the lines are released after edge C-1+T. An abort takes effect after the first edge that sees `cs_n` high. The bench changes every input on a falling edge. It reads the outputs at the falling edge that follows each rising edge, and compares them with the chunk that its own byte and chunk functions say belongs to that edge index, or with released lines.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;

  typedef enum logic [1:0] {
    MODE_EXT     = 2'd0,
    MODE_DUAL    = 2'd1,
    MODE_QUAD    = 2'd2,
    MODE_EXT_ALT = 2'd3
  } bus_mode_e;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_REPLY = 2'd1,
    PH_HOLD  = 2'd2
  } phase_e;

  // true for both single-line encodings
  function automatic logic is_single(bus_mode_e m);
    return (m == MODE_EXT) || (m == MODE_EXT_ALT);
  endfunction

  // index of the last command clock in a transfer
  function automatic logic [2:0] cmd_last_clk(bus_mode_e m);
    case (m)
      MODE_DUAL: return 3'd3;
      MODE_QUAD: return 3'd1;
      default:   return 3'd7;
    endcase
  endfunction

  // lines driven by the reply
  function automatic logic [3:0] lane_mask(bus_mode_e m);
    case (m)
      MODE_DUAL: return 4'b0011;
      MODE_QUAD: return 4'b1111;
      default:   return 4'b0010;
    endcase
  endfunction

endpackage

// File: rtl/spi_id_cmd_capture.sv
module spi_id_cmd_capture
  import spi_id_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       shift_en,
  input  bus_mode_e  mode,
  input  logic [3:0] dq_in,
  output logic [7:0] cmd_word
);

  logic [7:0] shreg;
  logic [7:0] shnext;

  // append the current chunk below the bits already collected
  always_comb begin
    case (mode)
      MODE_DUAL: shnext = {shreg[5:0], dq_in[1:0]};
      MODE_QUAD: shnext = {shreg[3:0], dq_in[3:0]};
      default:   shnext = {shreg[6:0], dq_in[0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      shreg <= '0;
    end else if (shift_en) begin
      shreg <= shnext;
    end
  end

  // full code as it stands once the current chunk is included
  assign cmd_word = shnext;

endmodule

// File: rtl/spi_id_reply_rom.sv
module spi_id_reply_rom #(
  parameter logic [7:0]             MFR_ID    = 8'h20,
  parameter logic [15:0]            DEV_ID    = 16'hBA20,
  parameter int                     UID_BYTES = 17,
  parameter logic [8*UID_BYTES-1:0] UID_VALUE = '0,
  localparam int                    MAX_BYTES = 3 + UID_BYTES,
  localparam int                    IDX_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       data
);

  logic [7:0] table_q [MAX_BYTES];

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_entry
    if (g == 0) begin : g_mfr
      assign table_q[g] = MFR_ID;
    end else if (g == 1) begin : g_dev_hi
      assign table_q[g] = DEV_ID[15:8];
    end else if (g == 2) begin : g_dev_lo
      assign table_q[g] = DEV_ID[7:0];
    end else begin : g_uid
      assign table_q[g] = UID_VALUE[8*(MAX_BYTES-g)-1 -: 8];
    end
  end

  always_comb begin
    if (idx < IDX_W'(MAX_BYTES)) begin
      data = table_q[idx];
    end else begin
      data = 8'h00;
    end
  end

endmodule

// File: rtl/spi_id_lane_slicer.sv
module spi_id_lane_slicer
  import spi_id_pkg::*;
(
  input  bus_mode_e  mode,
  input  logic [7:0] byte_val,
  input  logic [2:0] sub,
  output logic [3:0] bits,
  output logic [3:0] mask
);

  logic [2:0] shamt;
  logic [7:0] shifted;

  always_comb begin
    case (mode)
      MODE_DUAL: shamt = {sub[1:0], 1'b0};
      MODE_QUAD: shamt = {sub[0], 2'b00};
      default:   shamt = sub;
    endcase
    shifted = byte_val << shamt;
    case (mode)
      MODE_DUAL: bits = {2'b00, shifted[7:6]};
      MODE_QUAD: bits = shifted[7:4];
      default:   bits = {2'b00, shifted[7], 1'b0};
    endcase
    mask = lane_mask(mode);
  end

endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder
  import spi_id_pkg::*;
#(
  parameter logic [7:0]             MFR_ID     = 8'h20,
  parameter logic [15:0]            DEV_ID     = 16'hBA20,
  parameter int                     UID_BYTES  = 17,
  parameter logic [8*UID_BYTES-1:0] UID_VALUE  = 136'h5A_13_C7_E2_09_4B_8D_F1_36_72_AE_0C_D9_65_B8_21_4F,
  parameter logic [7:0]             CMD_ID     = 8'h9E,
  parameter logic [7:0]             CMD_MIO_ID = 8'hAF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic [1:0] mode,
  input  logic [3:0] dq_in,
  output logic [3:0] dq_out,
  output logic [3:0] dq_oe
);

  localparam int MAX_BYTES = 3 + UID_BYTES;
  localparam int POS_W     = $clog2(MAX_BYTES * 8 + 1);
  localparam int IDX_W     = $clog2(MAX_BYTES + 1);
  localparam int TOT_EXT   = MAX_BYTES * 8;
  localparam int TOT_DUAL  = 3 * 4;
  localparam int TOT_QUAD  = 3 * 2;

  bus_mode_e        bmode;
  phase_e           state;
  logic [2:0]       cyc;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] total;
  logic [IDX_W-1:0] bidx;
  logic [2:0]       sub;
  logic [7:0]       cur_byte;
  logic [7:0]       cmd_word;
  logic [3:0]       lane_bits;
  logic [3:0]       lane_msk;
  logic             last_cmd;
  logic             cmd_ok;

  assign bmode = bus_mode_e'(mode);

  spi_id_cmd_capture u_capture (
    .clk      (clk),
    .rst      (rst),
    .clear    (cs_n),
    .shift_en (state == PH_CMD),
    .mode     (bmode),
    .dq_in    (dq_in),
    .cmd_word (cmd_word)
  );

  // split the chunk position into byte index and chunk-within-byte
  always_comb begin
    case (bmode)
      MODE_DUAL: begin
        bidx  = IDX_W'(pos >> 2);
        sub   = {1'b0, pos[1:0]};
        total = POS_W'(TOT_DUAL);
      end
      MODE_QUAD: begin
        bidx  = IDX_W'(pos >> 1);
        sub   = {2'b00, pos[0]};
        total = POS_W'(TOT_QUAD);
      end
      default: begin
        bidx  = IDX_W'(pos >> 3);
        sub   = pos[2:0];
        total = POS_W'(TOT_EXT);
      end
    endcase
  end

  spi_id_reply_rom #(
    .MFR_ID    (MFR_ID),
    .DEV_ID    (DEV_ID),
    .UID_BYTES (UID_BYTES),
    .UID_VALUE (UID_VALUE)
  ) u_rom (
    .idx  (bidx),
    .data (cur_byte)
  );

  spi_id_lane_slicer u_slicer (
    .mode     (bmode),
    .byte_val (cur_byte),
    .sub      (sub),
    .bits     (lane_bits),
    .mask     (lane_msk)
  );

  assign last_cmd = (cyc == cmd_last_clk(bmode));
  assign cmd_ok   = is_single(bmode) ? (cmd_word == CMD_ID) : (cmd_word == CMD_MIO_ID);

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      state  <= PH_CMD;
      cyc    <= '0;
      pos    <= '0;
      dq_out <= '0;
      dq_oe  <= '0;
    end else begin
      case (state)
        PH_CMD: begin
          cyc <= cyc + 3'd1;
          if (last_cmd) begin
            if (cmd_ok) begin
              state  <= PH_REPLY;
              dq_out <= lane_bits;
              dq_oe  <= lane_msk;
              pos    <= pos + POS_W'(1);
            end else begin
              state <= PH_HOLD;
            end
          end
        end
        PH_REPLY: begin
          if (pos == total) begin
            dq_out <= '0;
            dq_oe  <= '0;
            state  <= PH_HOLD;
          end else begin
            dq_out <= lane_bits;
            dq_oe  <= lane_msk;
            pos    <= pos + POS_W'(1);
          end
        end
        default: begin
          dq_out <= '0;
          dq_oe  <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/spi_id_responder_checker.sv
module spi_id_responder_checker
  import spi_id_pkg::*;
#(
  parameter int UID_BYTES = 17
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic [1:0] mode,
  input logic [3:0] dq_oe
);

  localparam int MAX_BYTES = 3 + UID_BYTES;
  localparam int SAT       = 8 + MAX_BYTES * 8 + 1;
  localparam int CNT_W     = $clog2(SAT + 1);

  logic [CNT_W-1:0] edges;
  logic [CNT_W-1:0] need_c;
  logic [CNT_W-1:0] len_t;

  // rising edges seen with chip select low, saturating
  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      edges <= '0;
    end else if (edges != CNT_W'(SAT)) begin
      edges <= edges + CNT_W'(1);
    end
  end

  always_comb begin
    case (bus_mode_e'(mode))
      MODE_DUAL: begin need_c = CNT_W'(4); len_t = CNT_W'(12); end
      MODE_QUAD: begin need_c = CNT_W'(2); len_t = CNT_W'(6);  end
      default:   begin need_c = CNT_W'(8); len_t = CNT_W'(MAX_BYTES * 8); end
    endcase
  end

  AST_RESET_RELEASE: assert property (@(posedge clk) rst |=> (dq_oe == 4'b0000)); // R1

  AST_QUIET_IN_CMD: assert property (@(posedge clk) disable iff (rst)
    (dq_oe != 4'b0000) |-> (edges >= need_c)); // R2

  AST_LANE_SET: assert property (@(posedge clk) disable iff (rst)
    (dq_oe != 4'b0000) |-> (dq_oe == lane_mask(bus_mode_e'(mode)))); // R3

  AST_REPLY_END: assert property (@(posedge clk) disable iff (rst)
    (dq_oe != 4'b0000) |-> (edges < need_c + len_t)); // R6

  AST_CS_ABORT: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (dq_oe == 4'b0000)); // R8

endmodule

bind spi_id_responder spi_id_responder_checker #(.UID_BYTES(UID_BYTES)) u_checker (
  .clk   (clk),
  .rst   (rst),
  .cs_n  (cs_n),
  .mode  (mode),
  .dq_oe (dq_oe)
);

// File: tb/spi_id_responder_bench.sv
`timescale 1ns/1ps
module spi_id_responder_bench;

  localparam logic [7:0]   B_MFR   = 8'h2C;
  localparam logic [15:0]  B_DEV   = 16'hBB21;
  localparam int           B_UIDN  = 17;
  localparam logic [135:0] B_UID   = 136'h01_23_45_67_89_AB_CD_EF_FE_DC_BA_98_76_54_32_10_A5;
  localparam logic [7:0]   B_CMD1  = 8'h9E;
  localparam logic [7:0]   B_CMDM  = 8'hAF;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [3:0] dq_in = 4'h0;
  logic [3:0] dq_out;
  logic [3:0] dq_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  spi_id_responder #(
    .MFR_ID     (B_MFR),
    .DEV_ID     (B_DEV),
    .UID_BYTES  (B_UIDN),
    .UID_VALUE  (B_UID),
    .CMD_ID     (B_CMD1),
    .CMD_MIO_ID (B_CMDM)
  ) u_spi_id_responder (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .mode   (mode),
    .dq_in  (dq_in),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
  );

  function automatic int width_of(int m);
    return (m == 1) ? 2 : (m == 2) ? 4 : 1;
  endfunction

  function automatic int nbytes_of(int m);
    return (m == 1 || m == 2) ? 3 : 3 + B_UIDN;
  endfunction

  function automatic logic [3:0] mask_of(int m);
    return (m == 1) ? 4'b0011 : (m == 2) ? 4'b1111 : 4'b0010;
  endfunction

  function automatic logic [7:0] ref_byte(int k);
    if (k == 0) return B_MFR;
    if (k == 1) return B_DEV[15:8];
    if (k == 2) return B_DEV[7:0];
    return 8'(B_UID >> (8 * (B_UIDN - 1 - (k - 3))));
  endfunction

  function automatic logic [3:0] ref_chunk(int m, int p);
    int w = width_of(m);
    int per = 8 / w;
    int b = int'(ref_byte(p / per));
    int s = p % per;
    int v = (b >> (8 - w * (s + 1))) & ((1 << w) - 1);
    if (w == 1) v = v << 1;
    return 4'(v);
  endfunction

  task automatic check_out(string tag, logic [3:0] exp_oe, logic [3:0] exp_d);
    logic [7:0] act;
    logic [7:0] exp;
    act = {dq_oe, dq_out & dq_oe};
    exp = {exp_oe, exp_d & exp_oe};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {oe,data} got %h expected %h (mode %0d)", tag, act, exp, mode);
    end
  endtask

  task automatic run_txn(int m, logic [7:0] cmd, int nclk);
    int w = width_of(m);
    int c = 8 / w;
    int t = nbytes_of(m) * 8 / w;
    bit single = (m == 0 || m == 3);
    bit valid = single ? (cmd == B_CMD1) : (cmd == B_CMDM);
    string rtag = (m == 3) ? "R9" : (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
    @(negedge clk);
    mode = 2'(m);
    @(negedge clk);
    cs_n = 1'b0;
    for (int j = 0; j < nclk; j++) begin
      if (j < c) begin
        logic [3:0] ch = 4'((int'(cmd) >> (8 - w * (j + 1))) & ((1 << w) - 1));
        if (w == 1) dq_in = (4'($urandom) & 4'hE) | ch;
        else if (w == 2) dq_in = (4'($urandom) & 4'hC) | ch;
        else dq_in = ch;
      end else begin
        dq_in = 4'($urandom);
      end
      @(posedge clk);
      @(negedge clk);
      if (j < c - 1) begin
        check_out("R2", 4'b0000, 4'h0);
      end else if (!valid) begin
        check_out("R7", 4'b0000, 4'h0);
      end else if (j - (c - 1) < t) begin
        check_out(rtag, mask_of(m), ref_chunk(m, j - (c - 1)));
      end else begin
        check_out("R6", 4'b0000, 4'h0);
      end
    end
    cs_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_out("R8", 4'b0000, 4'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5EED));
    // R1: reset held while a valid quad command is presented
    mode = 2'd2;
    cs_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      dq_in = (i % 2 == 0) ? B_CMDM[7:4] : B_CMDM[3:0];
      @(posedge clk);
      @(negedge clk);
      if (i > 0) check_out("R1", 4'b0000, 4'h0);
    end
    cs_n = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // full replies in every mode, with trailing clocks for R6
    run_txn(0, B_CMD1, 8 + (3 + B_UIDN) * 8 + 3);
    run_txn(1, B_CMDM, 4 + 12 + 3);
    run_txn(2, B_CMDM, 2 + 6 + 3);
    run_txn(3, B_CMD1, 8 + (3 + B_UIDN) * 8 + 2);
    // R7: codes that do not belong to the mode
    run_txn(0, B_CMDM, 14);
    run_txn(1, B_CMD1, 10);
    run_txn(2, 8'h00, 8);
    run_txn(3, 8'h9F, 12);
    // R8: abort mid-reply and mid-command, then fresh transfers
    run_txn(0, B_CMD1, 20);
    run_txn(0, B_CMD1, 8 + (3 + B_UIDN) * 8 + 1);
    run_txn(1, B_CMDM, 2);
    run_txn(2, B_CMDM, 9);
    run_txn(1, B_CMDM, 7);
    run_txn(1, B_CMDM, 17);

    // random transfers
    for (int n = 0; n < 60; n++) begin
      int m = int'($urandom % 4);
      int sel = int'($urandom % 4);
      logic [7:0] cmd;
      int c = 8 / width_of(m);
      int t = nbytes_of(m) * 8 / width_of(m);
      if (sel == 0) cmd = 8'($urandom);
      else if (sel == 1) cmd = (m == 0 || m == 3) ? B_CMDM : B_CMD1;
      else cmd = (m == 0 || m == 3) ? B_CMD1 : B_CMDM;
      run_txn(m, cmd, 1 + int'($urandom % (c + t + 4)));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule